// File: doc/BRIEF.md
# Rank Sparing Failover Controller

This block watches correctable-error reports from a memory controller and keeps one spare rank per channel in reserve. Each channel is a separate sparing domain. Every populated, non-spare rank has a saturating error counter. When a counter reaches the programmed threshold, the channel starts a failover. The block asks a shared copy engine to move the failing rank's contents onto the spare rank. Once the engine reports completion, the block points the failing rank's remap entry at the spare and retires the failing rank.

A channel can fail over once and only once. After that it is non-redundant, and its later error reports are dropped. Counting carries on unchanged on the other channels. Separately, the very first correctable error seen anywhere is reported once on a logging output and never again.

Error reports arrive on a valid/ready stream whose ready is tied high, so a report is accepted whenever valid is high. Copy requests leave on a valid/ready stream. A presented request, with its channel, source and destination, holds steady until the engine takes it, even if other channels begin requesting meanwhile. Completion comes back as a plain one-cycle pulse tagged with a channel.

Top module: `rank_spare_ctrl`

## Requirements
- R1: After reset every remap entry is the identity, and no rank is retired. No failover event, copy request or log pulse is active.
- R2: The spare of a channel is its largest populated rank, with the lowest index winning a tie. The spare is never counted against.
- R3: Sparing is active on a channel only when all of the following hold:
  - the enable is high;
  - a rank is populated;
  - its module slots (2-bit code: 0 empty, 1 single-rank, 2 dual-rank, 3 quad-rank) hold either two or more single/dual-rank modules or at least one quad-rank module.
  An inactive channel neither counts nor fails over.
- R4: Each accepted report on a populated non-spare rank of an active redundant channel adds one to that rank's counter. The counter saturates at its maximum. A counter at or above a non-zero threshold starts failover; a threshold of zero starts none.
- R5: When several ranks of one channel are at or above the threshold in the same cycle, the lowest-numbered one is chosen.
- R6: One cycle after the crossing, the channel's event bit pulses for one cycle with the failing rank. In the same cycle a copy request appears with source = failing rank and destination = spare. A presented request keeps valid, channel, source and destination stable until accepted.
- R7: The remap entry of the failing rank changes to the spare, and its retired bit sets, only on a completion pulse for that channel after its request was accepted. A completion for any other channel leaves everything unchanged.
- R8: After failover, a channel never raises another event, and its error reports are ignored.
- R9: The first accepted error report after reset produces a single one-cycle log pulse on the next cycle, carrying its channel and rank. No later report produces one.
- R10: A failover on one channel does not stop counting or failover on the other channels.
- R11: The usable capacity is the sum of populated rank sizes minus the spare size of each channel with active sparing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spare_en | input | 1 | Global sparing enable |
| thresh | input | CNT_W | Error threshold; zero disables failover |
| slot_kind | input | NCH*NSLOT*2 | Module type per slot per channel |
| rank_present | input | NCH*NRK | Rank populated flags |
| rank_size | input | NCH*NRK*SIZE_W | Rank size per rank |
| err_valid | input | 1 | Error report valid |
| err_ready | output | 1 | Error report ready (always high) |
| err_chan | input | CH_W | Channel of the report |
| err_rank | input | RK_W | Rank of the report |
| copy_valid | output | 1 | Copy request valid |
| copy_ready | input | 1 | Copy engine accepts request |
| copy_chan | output | CH_W | Channel to copy within |
| copy_src | output | RK_W | Failing rank (source) |
| copy_dst | output | RK_W | Spare rank (destination) |
| copy_done | input | 1 | Copy completion pulse |
| copy_done_chan | input | CH_W | Channel of the completed copy |
| spare_rank | output | NCH*RK_W | Spare rank per channel |
| spare_active | output | NCH | Sparing active per channel |
| usable_cap | output | CAP_W | Usable capacity |
| remap | output | NCH*NRK*RK_W | Physical rank for each logical rank |
| rank_retired | output | NCH*NRK | Retired rank flags |
| sfo_evt | output | NCH | Failover start pulse per channel |
| sfo_rank | output | NCH*RK_W | Failing rank per channel |
| first_log_valid | output | 1 | First-error log pulse |
| first_log_chan | output | CH_W | Channel of first error |
| first_log_rank | output | RK_W | Rank of first error |

## Verification
The counting path is first driven with a seeded random stream of reports over all ranks of one channel, spare included, while the threshold is held at zero. The threshold is then raised to the highest count. This separates correct per-rank counting and spare exclusion from a wrong pick among tied or multiple crossings. A directed burst past the counter's top on the other channel, followed by a threshold equal to the maximum, tells saturation apart from wrap-around. Further directed cases cover these situations:
- a completion arriving for the wrong channel;
- a copy request held under back-pressure while a second channel fails;
- errors sent to an already failed channel;
- module populations that are not eligible for sparing.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
  typedef enum logic [1:0] {
    ST_REDUNDANT = 2'd0,
    ST_COPYING   = 2'd1,
    ST_NONRED    = 2'd2
  } chan_st_e;

  localparam logic [1:0] SLOT_EMPTY = 2'd0;
  localparam logic [1:0] SLOT_SR    = 2'd1;
  localparam logic [1:0] SLOT_DR    = 2'd2;
  localparam logic [1:0] SLOT_QR    = 2'd3;
endpackage

// File: rtl/rsf_spare_pick.sv
module rsf_spare_pick
  import rsf_pkg::*;
#(
  parameter int NRK    = 4,
  parameter int NSLOT  = 2,
  parameter int SIZE_W = 4,
  parameter int RK_W   = 2,
  parameter int CAP_W  = 8
) (
  input  logic                  sparing_on,
  input  logic [NRK-1:0]        present,
  input  logic [NRK*SIZE_W-1:0] sizes,
  input  logic [NSLOT*2-1:0]    slots,
  output logic [RK_W-1:0]       spare_rank,
  output logic                  spare_ok,
  output logic [CAP_W-1:0]      installed,
  output logic [CAP_W-1:0]      reserved
);
  logic              found;
  logic [SIZE_W-1:0] best;
  logic              has_quad;
  int                n_small;

  always_comb begin
    found      = 1'b0;
    best       = '0;
    spare_rank = '0;
    installed  = '0;
    for (int r = 0; r < NRK; r++) begin
      if (present[r]) begin
        installed = installed + CAP_W'(sizes[r*SIZE_W +: SIZE_W]);
        // strict compare keeps the lowest index on a tie
        if (!found || sizes[r*SIZE_W +: SIZE_W] > best) begin
          found      = 1'b1;
          best       = sizes[r*SIZE_W +: SIZE_W];
          spare_rank = RK_W'(r);
        end
      end
    end
  end

  always_comb begin
    n_small  = 0;
    has_quad = 1'b0;
    for (int s = 0; s < NSLOT; s++) begin
      if (slots[s*2 +: 2] == SLOT_SR || slots[s*2 +: 2] == SLOT_DR) n_small = n_small + 1;
      if (slots[s*2 +: 2] == SLOT_QR) has_quad = 1'b1;
    end
    spare_ok = sparing_on && found && (n_small >= 2 || has_quad);
    reserved = spare_ok ? CAP_W'(best) : '0;
  end
endmodule

// File: rtl/rsf_err_count.sv
module rsf_err_count #(
  parameter int NCH   = 2,
  parameter int NRK   = 4,
  parameter int CNT_W = 4,
  parameter int CH_W  = 1,
  parameter int RK_W  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                err_fire,
  input  logic [CH_W-1:0]     err_chan,
  input  logic [RK_W-1:0]     err_rank,
  input  logic [NCH-1:0]      count_en,
  input  logic [NCH*NRK-1:0]  rank_ok,
  input  logic [CNT_W-1:0]    thresh,
  output logic [NCH-1:0]      hit,
  output logic [NCH*RK_W-1:0] hit_rank
);
  localparam int NCTR = NCH * NRK;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q [NCTR];
  logic [NCTR-1:0]  crossed;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    for (genvar r = 0; r < NRK; r++) begin : g_rk
      localparam int IDX = c * NRK + r;
      logic bump;
      assign bump = err_fire && (err_chan == CH_W'(c)) && (err_rank == RK_W'(r))
                    && count_en[c] && rank_ok[IDX];

      always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_q[IDX] <= '0;
        else if (bump && cnt_q[IDX] != CNT_MAX) cnt_q[IDX] <= cnt_q[IDX] + 1'b1;
      end

      assign crossed[IDX] = (thresh != '0) && (cnt_q[IDX] >= thresh)
                            && rank_ok[IDX] && count_en[c];

      assert_cnt_saturates_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q[IDX] == CNT_MAX |=> cnt_q[IDX] == CNT_MAX);
    end
  end

  always_comb begin
    hit      = '0;
    hit_rank = '0;
    for (int c = 0; c < NCH; c++) begin
      for (int r = NRK - 1; r >= 0; r--) begin
        if (crossed[c*NRK + r]) begin
          hit[c]                     = 1'b1;
          hit_rank[c*RK_W +: RK_W]   = RK_W'(r);
        end
      end
    end
  end
endmodule

// File: rtl/rsf_chan_fsm.sv
module rsf_chan_fsm
  import rsf_pkg::*;
#(
  parameter int RK_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic            hit,
  input  logic [RK_W-1:0] hit_rank,
  input  logic [RK_W-1:0] spare_rank,
  input  logic            grant,
  input  logic            done,
  output chan_st_e        state_o,
  output logic [RK_W-1:0] fail_rank_o,
  output logic [RK_W-1:0] spare_lat_o,
  output logic            req_o,
  output logic            evt_o
);
  chan_st_e        st_q;
  logic            issued_q;
  logic            evt_q;
  logic [RK_W-1:0] fail_q;
  logic [RK_W-1:0] spare_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_REDUNDANT;
      issued_q <= 1'b0;
      evt_q    <= 1'b0;
      fail_q   <= '0;
      spare_q  <= '0;
    end else begin
      evt_q <= 1'b0;
      unique case (st_q)
        ST_REDUNDANT: if (active && hit) begin
          st_q     <= ST_COPYING;
          fail_q   <= hit_rank;
          spare_q  <= spare_rank;
          issued_q <= 1'b0;
          evt_q    <= 1'b1;
        end
        ST_COPYING: begin
          if (grant) issued_q <= 1'b1;
          if (issued_q && done) st_q <= ST_NONRED;
        end
        default: st_q <= ST_NONRED;
      endcase
    end
  end

  assign state_o     = st_q;
  assign fail_rank_o = fail_q;
  assign spare_lat_o = spare_q;
  assign req_o       = (st_q == ST_COPYING) && !issued_q;
  assign evt_o       = evt_q;

  assert_once_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_NONRED |=> st_q == ST_NONRED && !evt_q);
  assert_wait_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_COPYING && !done) |=> st_q == ST_COPYING);
  assert_evt_enters_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |-> st_q == ST_COPYING && !issued_q);
endmodule

// File: rtl/rsf_copy_arb.sv
module rsf_copy_arb #(
  parameter int NCH  = 2,
  parameter int CH_W = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  req,
  input  logic            copy_ready,
  output logic            copy_valid,
  output logic [CH_W-1:0] copy_chan,
  output logic [NCH-1:0]  grant
);
  logic            lock_q;
  logic [CH_W-1:0] lock_ch_q;

  always_comb begin
    copy_valid = 1'b0;
    copy_chan  = '0;
    if (lock_q) begin
      copy_valid = 1'b1;
      copy_chan  = lock_ch_q;
    end else begin
      for (int c = NCH - 1; c >= 0; c--) begin
        if (req[c]) begin
          copy_valid = 1'b1;
          copy_chan  = CH_W'(c);
        end
      end
    end
    for (int c = 0; c < NCH; c++) grant[c] = copy_valid && copy_ready && (copy_chan == CH_W'(c));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q    <= 1'b0;
      lock_ch_q <= '0;
    end else if (copy_valid && !copy_ready) begin
      lock_q    <= 1'b1;
      lock_ch_q <= copy_chan;
    end else if (copy_valid && copy_ready) begin
      lock_q    <= 1'b0;
    end
  end

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_valid && !copy_ready) |=> copy_valid && $stable(copy_chan));
  assert_single_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
endmodule

// File: rtl/rank_spare_ctrl.sv
module rank_spare_ctrl
  import rsf_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int NRK    = 4,
  parameter int NSLOT  = 2,
  parameter int CNT_W  = 4,
  parameter int SIZE_W = 4,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int RK_W  = (NRK > 1) ? $clog2(NRK) : 1,
  localparam int CAP_W = SIZE_W + $clog2(NCH * NRK) + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      spare_en,
  input  logic [CNT_W-1:0]          thresh,
  input  logic [NCH*NSLOT*2-1:0]    slot_kind,
  input  logic [NCH*NRK-1:0]        rank_present,
  input  logic [NCH*NRK*SIZE_W-1:0] rank_size,
  input  logic                      err_valid,
  output logic                      err_ready,
  input  logic [CH_W-1:0]           err_chan,
  input  logic [RK_W-1:0]           err_rank,
  output logic                      copy_valid,
  input  logic                      copy_ready,
  output logic [CH_W-1:0]           copy_chan,
  output logic [RK_W-1:0]           copy_src,
  output logic [RK_W-1:0]           copy_dst,
  input  logic                      copy_done,
  input  logic [CH_W-1:0]           copy_done_chan,
  output logic [NCH*RK_W-1:0]       spare_rank,
  output logic [NCH-1:0]            spare_active,
  output logic [CAP_W-1:0]          usable_cap,
  output logic [NCH*NRK*RK_W-1:0]   remap,
  output logic [NCH*NRK-1:0]        rank_retired,
  output logic [NCH-1:0]            sfo_evt,
  output logic [NCH*RK_W-1:0]       sfo_rank,
  output logic                      first_log_valid,
  output logic [CH_W-1:0]           first_log_chan,
  output logic [RK_W-1:0]           first_log_rank
);
  logic             err_fire;
  logic [CAP_W-1:0] inst_cap [NCH];
  logic [CAP_W-1:0] resv_cap [NCH];
  logic [NCH-1:0]   count_en, hit, req, grant;
  logic [NCH*NRK-1:0]  rank_ok;
  logic [NCH*RK_W-1:0] hit_rank, fail_flat, spare_lat_flat;
  chan_st_e         ch_st [NCH];

  assign err_ready = 1'b1;
  assign err_fire  = err_valid && err_ready;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    rsf_spare_pick #(
      .NRK(NRK), .NSLOT(NSLOT), .SIZE_W(SIZE_W), .RK_W(RK_W), .CAP_W(CAP_W)
    ) u_pick (
      .sparing_on (spare_en),
      .present    (rank_present[c*NRK +: NRK]),
      .sizes      (rank_size[c*NRK*SIZE_W +: NRK*SIZE_W]),
      .slots      (slot_kind[c*NSLOT*2 +: NSLOT*2]),
      .spare_rank (spare_rank[c*RK_W +: RK_W]),
      .spare_ok   (spare_active[c]),
      .installed  (inst_cap[c]),
      .reserved   (resv_cap[c])
    );

    for (genvar r = 0; r < NRK; r++) begin : g_ok
      assign rank_ok[c*NRK + r] = rank_present[c*NRK + r]
                                  && (spare_rank[c*RK_W +: RK_W] != RK_W'(r));
    end

    assign count_en[c] = spare_active[c] && (ch_st[c] == ST_REDUNDANT);

    rsf_chan_fsm #(.RK_W(RK_W)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .active      (spare_active[c]),
      .hit         (hit[c]),
      .hit_rank    (hit_rank[c*RK_W +: RK_W]),
      .spare_rank  (spare_rank[c*RK_W +: RK_W]),
      .grant       (grant[c]),
      .done        (copy_done && copy_done_chan == CH_W'(c)),
      .state_o     (ch_st[c]),
      .fail_rank_o (fail_flat[c*RK_W +: RK_W]),
      .spare_lat_o (spare_lat_flat[c*RK_W +: RK_W]),
      .req_o       (req[c]),
      .evt_o       (sfo_evt[c])
    );

    for (genvar r = 0; r < NRK; r++) begin : g_map
      logic swapped;
      assign swapped = (ch_st[c] == ST_NONRED) && (fail_flat[c*RK_W +: RK_W] == RK_W'(r));
      assign remap[(c*NRK + r)*RK_W +: RK_W] = swapped ? spare_lat_flat[c*RK_W +: RK_W] : RK_W'(r);
      assign rank_retired[c*NRK + r] = swapped;
    end
  end

  assign sfo_rank = fail_flat;

  rsf_err_count #(
    .NCH(NCH), .NRK(NRK), .CNT_W(CNT_W), .CH_W(CH_W), .RK_W(RK_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .err_fire (err_fire),
    .err_chan (err_chan),
    .err_rank (err_rank),
    .count_en (count_en),
    .rank_ok  (rank_ok),
    .thresh   (thresh),
    .hit      (hit),
    .hit_rank (hit_rank)
  );

  rsf_copy_arb #(.NCH(NCH), .CH_W(CH_W)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .copy_ready (copy_ready),
    .copy_valid (copy_valid),
    .copy_chan  (copy_chan),
    .grant      (grant)
  );

  assign copy_src = fail_flat[copy_chan*RK_W +: RK_W];
  assign copy_dst = spare_lat_flat[copy_chan*RK_W +: RK_W];

  always_comb begin
    usable_cap = '0;
    for (int c = 0; c < NCH; c++) usable_cap = usable_cap + inst_cap[c] - resv_cap[c];
  end

  logic seen_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q          <= 1'b0;
      first_log_valid <= 1'b0;
      first_log_chan  <= '0;
      first_log_rank  <= '0;
    end else begin
      first_log_valid <= 1'b0;
      if (err_fire && !seen_q) begin
        seen_q          <= 1'b1;
        first_log_valid <= 1'b1;
        first_log_chan  <= err_chan;
        first_log_rank  <= err_rank;
      end
    end
  end

  assert_log_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    first_log_valid |=> !first_log_valid && seen_q);
  assert_src_not_spare_R2: assert property (@(posedge clk) disable iff (!rst_n)
    copy_valid |-> copy_src != copy_dst);
endmodule

// File: tb/rank_spare_ctrl_bench.sv
`timescale 1ns/1ps
module rank_spare_ctrl_bench;
  localparam int NCH = 2, NRK = 4, NSLOT = 2, CNT_W = 4, SIZE_W = 4;
  localparam int CH_W = 1, RK_W = 2, CAP_W = 8;

  logic clk = 1'b0, rst_n = 1'b0, spare_en = 1'b0;
  logic [CNT_W-1:0] thresh = '0;
  logic [NCH*NSLOT*2-1:0] slot_kind = '0;
  logic [NCH*NRK-1:0] rank_present = '0;
  logic [NCH*NRK*SIZE_W-1:0] rank_size = '0;
  logic err_valid = 1'b0, err_ready;
  logic [CH_W-1:0] err_chan = '0;
  logic [RK_W-1:0] err_rank = '0;
  logic copy_valid, copy_ready = 1'b0;
  logic [CH_W-1:0] copy_chan;
  logic [RK_W-1:0] copy_src, copy_dst;
  logic copy_done = 1'b0;
  logic [CH_W-1:0] copy_done_chan = '0;
  logic [NCH*RK_W-1:0] spare_rank, sfo_rank;
  logic [NCH-1:0] spare_active, sfo_evt;
  logic [CAP_W-1:0] usable_cap;
  logic [NCH*NRK*RK_W-1:0] remap;
  logic [NCH*NRK-1:0] rank_retired;
  logic first_log_valid;
  logic [CH_W-1:0] first_log_chan;
  logic [RK_W-1:0] first_log_rank;

  rank_spare_ctrl u_rank_spare_ctrl (.*);

  always #2 clk = ~clk;

  int nchk = 0, nfail = 0, thr_m = 0;
  int sz [NCH][NRK] = '{'{2, 4, 4, 1}, '{1, 1, 3, 2}};
  int cnt [NCH][NRK];
  int st [NCH];
  int fr [NCH];
  bit act [NCH];
  bit seen = 0, fin = 0;

  task automatic chk(string what, int actual, int expected);
    nchk++;
    if (actual != expected) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", what, actual, expected);
    end
  endtask

  function automatic int pick_spare(int c);
    int b = 0;
    for (int r = 1; r < NRK; r++) if (sz[c][r] > sz[c][b]) b = r;
    return b;
  endfunction

  function automatic int exp_cap();
    int s = 0;
    for (int c = 0; c < NCH; c++) begin
      for (int r = 0; r < NRK; r++) s += sz[c][r];
      if (act[c]) s -= sz[c][pick_spare(c)];
    end
    return s;
  endfunction

  function automatic int pick_fail(int c);
    if (thr_m == 0) return -1;
    for (int r = 0; r < NRK; r++)
      if (r != pick_spare(c) && cnt[c][r] >= thr_m) return r;
    return -1;
  endfunction

  function automatic int map_of(int c, int r);
    return int'(remap[(c*NRK + r)*RK_W +: RK_W]);
  endfunction

  task automatic eval_fail(string tag);
    logic [NCH-1:0] m = '0;
    int f [NCH];
    for (int c = 0; c < NCH; c++) begin
      f[c] = -1;
      if (st[c] == 0 && act[c]) f[c] = pick_fail(c);
      if (f[c] >= 0) m[c] = 1'b1;
    end
    chk({tag, " event mask"}, int'(sfo_evt), int'(m));
    for (int c = 0; c < NCH; c++) if (m[c]) begin
      chk({tag, " failing rank"}, int'(sfo_rank[c*RK_W +: RK_W]), f[c]);
      st[c] = 1;
      fr[c] = f[c];
    end
  endtask

  task automatic send_err(int c, int r, string tag);
    @(negedge clk);
    err_valid = 1'b1; err_chan = CH_W'(c); err_rank = RK_W'(r);
    @(negedge clk);
    err_valid = 1'b0;
    if (!seen) begin
      chk("R9 first log valid", int'(first_log_valid), 1);
      chk("R9 first log chan", int'(first_log_chan), c);
      chk("R9 first log rank", int'(first_log_rank), r);
      seen = 1;
    end else chk("R9 no later log", int'(first_log_valid), 0);
    if (st[c] == 0 && act[c] && r != pick_spare(c) && cnt[c][r] < 15) cnt[c][r]++;
    @(negedge clk);
    eval_fail(tag);
  endtask

  task automatic set_thr(int t, string tag);
    @(negedge clk);
    thresh = CNT_W'(t); thr_m = t;
    @(negedge clk);
    eval_fail(tag);
  endtask

  task automatic set_slots(int c, int k0, int k1);
    slot_kind[(c*NSLOT)*2 +: 2] = 2'(k0);
    slot_kind[(c*NSLOT + 1)*2 +: 2] = 2'(k1);
  endtask

  task automatic accept();
    @(negedge clk); copy_ready = 1'b1;
    @(negedge clk); copy_ready = 1'b0;
  endtask

  task automatic send_done(int c);
    @(negedge clk); copy_done = 1'b1; copy_done_chan = CH_W'(c);
    @(negedge clk); copy_done = 1'b0;
  endtask

  initial begin
    #800000;
    if (!fin) begin
      nfail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int seed, tmax;
    seed = $urandom(32'd4242);
    for (int c = 0; c < NCH; c++) begin
      st[c] = 0; fr[c] = 0; act[c] = 1;
      for (int r = 0; r < NRK; r++) begin
        cnt[c][r] = 0;
        rank_size[(c*NRK + r)*SIZE_W +: SIZE_W] = SIZE_W'(sz[c][r]);
      end
    end
    rank_present = '1;
    set_slots(0, 2, 2);
    set_slots(1, 3, 0);
    spare_en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < NRK; r++) chk("R1 identity remap", map_of(c, r), r);
    chk("R1 retired", int'(rank_retired), 0);
    chk("R1 copy idle", int'(copy_valid), 0);
    chk("R1 no event", int'(sfo_evt), 0);
    chk("R1 no log", int'(first_log_valid), 0);
    // R2 spare choice, R11 capacity
    for (int c = 0; c < NCH; c++) chk("R2 spare rank", int'(spare_rank[c*RK_W +: RK_W]), pick_spare(c));
    chk("R3 both active", int'(spare_active), 3);
    chk("R11 capacity", int'(usable_cap), exp_cap());
    // R3 eligibility: one single-rank module only
    set_slots(1, 1, 0); act[1] = 0;
    @(negedge clk);
    chk("R3 ch1 inactive", int'(spare_active), 1);
    chk("R11 capacity inactive ch", int'(usable_cap), exp_cap());
    spare_en = 1'b0; act[0] = 0;
    @(negedge clk);
    chk("R3 disabled", int'(spare_active), 0);
    chk("R11 capacity disabled", int'(usable_cap), exp_cap());
    spare_en = 1'b1; act[0] = 1;
    set_thr(1, "R3");
    send_err(1, 0, "R3 inactive no failover");
    send_err(1, 1, "R3 inactive no failover");
    set_thr(0, "R4 zero threshold");
    set_slots(1, 3, 0); act[1] = 1;
    @(negedge clk);
    chk("R3 quad eligible", int'(spare_active), 3);
    // R4/R5 random stream on ch0 with counting only
    for (int i = 0; i < 40; i++) send_err(0, int'($urandom % 4), "R4 zero threshold");
    tmax = 1;
    for (int r = 0; r < NRK; r++) if (r != pick_spare(0) && cnt[0][r] > tmax) tmax = cnt[0][r];
    set_thr(tmax, "R5 lowest crossing");
    chk("R6 copy valid", int'(copy_valid), 1);
    chk("R6 copy chan", int'(copy_chan), 0);
    chk("R6 copy src", int'(copy_src), fr[0]);
    chk("R6 copy dst", int'(copy_dst), pick_spare(0));
    repeat (3) begin
      @(negedge clk);
      chk("R6 held valid", int'(copy_valid), 1);
      chk("R6 held chan", int'(copy_chan), 0);
      chk("R6 no repeat event", int'(sfo_evt), 0);
    end
    // R10/R4 ch1 keeps counting and saturates
    set_thr(0, "R10");
    for (int i = 0; i < 20; i++) send_err(1, 3, "R10 counting continues");
    send_err(1, 0, "R10 counting continues");
    send_err(1, 0, "R10 counting continues");
    set_thr(15, "R4 saturated crossing");
    chk("R6 hold under second request", int'(copy_chan), 0);
    // R7 foreign completion ignored
    send_done(1);
    chk("R7 ch1 untouched", map_of(1, 3), 3);
    chk("R7 ch0 untouched", map_of(0, fr[0]), fr[0]);
    chk("R7 no retire", int'(rank_retired), 0);
    accept();
    chk("R6 next request chan", int'(copy_chan), 1);
    chk("R6 next request src", int'(copy_src), fr[1]);
    chk("R6 next request dst", int'(copy_dst), pick_spare(1));
    chk("R7 no remap before done", map_of(0, fr[0]), fr[0]);
    send_done(0); st[0] = 2;
    chk("R7 remap ch0", map_of(0, fr[0]), pick_spare(0));
    chk("R7 retired ch0", int'(rank_retired[fr[0]]), 1);
    chk("R7 ch1 still identity", map_of(1, fr[1]), fr[1]);
    accept();
    chk("R6 queue empty", int'(copy_valid), 0);
    send_done(1); st[1] = 2;
    chk("R7 remap ch1", map_of(1, fr[1]), pick_spare(1));
    chk("R7 retired ch1", int'(rank_retired[NRK + fr[1]]), 1);
    // R8 failed channels ignore further errors
    set_thr(1, "R8");
    for (int i = 0; i < 6; i++) send_err(i % 2, int'($urandom % 4), "R8 no second failover");
    chk("R8 copy idle", int'(copy_valid), 0);
    chk("R11 capacity after failover", int'(usable_cap), exp_cap());
    fin = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule